// File: doc/BRIEF.md
# Functional-Unit Hazard Scoreboard

This block is the central hazard controller for a small core with several non-pipelined functional units. Each instruction moves through four stages: issue, operand read, execute and result write. Because no unit is pipelined, an in-flight instruction is named by the id of the unit that holds it. The controller keeps one status entry per unit and a table that records, for each register, which unit will write it next. From these it decides each cycle whether the head instruction may issue, which units may read their operands, and which finished unit may write its result.

The front end presents one instruction at a time. The instruction carries the id of the unit it needs, an operation code, a destination register and two source registers. The front end holds the instruction until `iss_ready` is high. This keeps issue in order, because a stalled instruction blocks the ones behind it. Each unit's datapath reads the register file in the cycle its `rd_grant` bit is high. It pulses its `ex_done` bit when its arithmetic is finished, and it writes the register file in the cycle its `wb_grant` bit is high. The stored operation and register fields of every unit are presented on flat output buses for the datapath to use. The block has no commit stage, so interrupts are imprecise.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset no unit is busy, `iss_ready` is high for any unit and destination, and `rd_grant` and `wb_grant` are all zero.
- R2: An instruction that names a busy unit is not accepted (`iss_ready` low). This holds up to and including that unit's `wb_grant` cycle. `iss_ready` rises in the following cycle.
- R3: An instruction whose destination register already has a pending producer is not accepted (write-after-write). It becomes acceptable in the cycle after that producer's `wb_grant`.
- R4: An accepted instruction whose sources have no pending producer receives `rd_grant` for exactly one cycle. That cycle is the cycle after acceptance.
- R5: An instruction whose source has a pending producer receives `rd_grant` no earlier than the cycle after that producer's `wb_grant`.
- R6: A finished unit is not granted a write while another unit holds an unread source equal to its destination register (write-after-read). It may be granted from the cycle after that reader's `rd_grant`.
- R7: At most one `wb_grant` bit is high per cycle. Among eligible finished units the lowest id wins, and the others wait for a later cycle.
- R8: An `ex_done` pulse is ignored unless its unit has read its operands and is executing. Such a pulse never leads to a write grant.
- R9: A unit executing when its `ex_done` bit is high receives `wb_grant` in the next cycle, provided no hazard blocks it.
- R10: From acceptance until its write grant, unit u presents the accepted operation on `fu_op[u*OP_W +: OP_W]`. It presents the destination on `fu_dst[u*REG_W +: REG_W]` and the sources on `fu_src1` and `fu_src2` at the same offsets.
- R11: A source whose producer is granted its write in the same cycle the consumer is accepted counts as available. The consumer gets `rd_grant` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Head instruction present |
| iss_unit | input | FU_W | Functional unit the instruction needs |
| iss_op | input | OP_W | Operation code passed to the unit |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_ready | output | 1 | Head instruction may issue this cycle |
| ex_done | input | NUM_FU | Per-unit execution finished pulse |
| rd_grant | output | NUM_FU | Per-unit operand read permission |
| wb_grant | output | NUM_FU | Per-unit result write permission, one-hot or zero |
| fu_op | output | NUM_FU*OP_W | Stored operation of each unit |
| fu_dst | output | NUM_FU*REG_W | Stored destination of each unit |
| fu_src1 | output | NUM_FU*REG_W | Stored first source of each unit |
| fu_src2 | output | NUM_FU*REG_W | Stored second source of each unit |

## Verification
The bench builds the hazard shapes in which an off-by-one or a missed condition shows at the grant pins. It holds a second writer of a register behind an older reader that has not yet read. A design that checked write-after-read at issue, or not at all, would grant that write too early or stall the whole pipe. It lets a consumer issue in the very cycle its producer writes. A design without that bypass would leave the consumer waiting for a broadcast that already passed, so it would never read. It also raises two finishes at once, which tests priority, and sends a stray `ex_done` to a unit still waiting on operands. A wrong priority grants the higher id first, and honouring the stray pulse produces a write from a unit that never executed.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Life cycle of one functional-unit entry
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // free
    ST_OPS  = 2'd1,  // issued, waiting for operands
    ST_EXEC = 2'd2,  // operands read, executing
    ST_WB   = 2'd3   // finished, waiting for write permission
  } fu_stage_t;

endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_REG = 16,
  parameter int FU_W    = 2,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [FU_W-1:0]  set_fu,
  input  logic             clr_en,
  input  logic [FU_W-1:0]  clr_fu,
  input  logic [REG_W-1:0] lk_dst,
  input  logic [REG_W-1:0] lk_s1,
  input  logic [REG_W-1:0] lk_s2,
  output logic             dst_pend,
  output logic             s1_pend,
  output logic [FU_W-1:0]  s1_fu,
  output logic             s2_pend,
  output logic [FU_W-1:0]  s2_fu
);

  logic [NUM_REG-1:0]           pend_q, pend_d;
  logic [NUM_REG-1:0][FU_W-1:0] own_q, own_d;

  always_comb begin
    pend_d = pend_q;
    own_d  = own_q;
    if (clr_en) begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (pend_q[r] && own_q[r] == clr_fu) pend_d[r] = 1'b0;
      end
    end
    if (set_en) begin
      pend_d[set_reg] = 1'b1;
      own_d[set_reg]  = set_fu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      own_q  <= '0;
    end else begin
      pend_q <= pend_d;
      own_q  <= own_d;
    end
  end

  assign dst_pend = pend_q[lk_dst];
  assign s1_pend  = pend_q[lk_s1];
  assign s1_fu    = own_q[lk_s1];
  assign s2_pend  = pend_q[lk_s2];
  assign s2_fu    = own_q[lk_s2];

  // R3: a register never gets a second producer while one is pending
  a_r3_single_producer: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !pend_q[set_reg]);

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int FU_W  = 2,
  parameter int REG_W = 4,
  parameter int OP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [OP_W-1:0]  is_op,
  input  logic [REG_W-1:0] is_dst,
  input  logic [REG_W-1:0] is_src1,
  input  logic [REG_W-1:0] is_src2,
  input  logic             is_rdy1,
  input  logic [FU_W-1:0]  is_tag1,
  input  logic             is_rdy2,
  input  logic [FU_W-1:0]  is_tag2,
  input  logic             ex_done,
  input  logic             bc_valid,
  input  logic [FU_W-1:0]  bc_unit,
  input  logic             wb_win,
  output logic             busy,
  output logic             rd_grant,
  output logic             wb_req,
  output logic [OP_W-1:0]  op,
  output logic [REG_W-1:0] fi,
  output logic [REG_W-1:0] fj,
  output logic [REG_W-1:0] fk,
  output logic             rj,
  output logic             rk
);

  fu_stage_t        stage_q, stage_d;
  logic [OP_W-1:0]  op_q, op_d;
  logic [REG_W-1:0] fi_q, fi_d, fj_q, fj_d, fk_q, fk_d;
  logic [FU_W-1:0]  qj_q, qj_d, qk_q, qk_d;
  logic             qjv_q, qjv_d, qkv_q, qkv_d;
  logic             rj_q, rj_d, rk_q, rk_d;

  always_comb begin
    stage_d = stage_q;
    op_d    = op_q;
    fi_d    = fi_q;
    fj_d    = fj_q;
    fk_d    = fk_q;
    qj_d    = qj_q;
    qk_d    = qk_q;
    qjv_d   = qjv_q;
    qkv_d   = qkv_q;
    rj_d    = rj_q;
    rk_d    = rk_q;
    unique case (stage_q)
      ST_IDLE: begin
        if (issue_en) begin
          op_d    = is_op;
          fi_d    = is_dst;
          fj_d    = is_src1;
          fk_d    = is_src2;
          rj_d    = is_rdy1;
          rk_d    = is_rdy2;
          qj_d    = is_tag1;
          qk_d    = is_tag2;
          qjv_d   = !is_rdy1;
          qkv_d   = !is_rdy2;
          stage_d = ST_OPS;
        end
      end
      ST_OPS: begin
        // result broadcast from a writing unit
        if (bc_valid && qjv_q && qj_q == bc_unit) begin
          rj_d  = 1'b1;
          qjv_d = 1'b0;
        end
        if (bc_valid && qkv_q && qk_q == bc_unit) begin
          rk_d  = 1'b1;
          qkv_d = 1'b0;
        end
        // operand read: drop ready flags so WAR checks stop counting us
        if (rj_q && rk_q) begin
          rj_d    = 1'b0;
          rk_d    = 1'b0;
          stage_d = ST_EXEC;
        end
      end
      ST_EXEC: if (ex_done) stage_d = ST_WB;
      ST_WB:   if (wb_win)  stage_d = ST_IDLE;
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      op_q    <= '0;
      fi_q    <= '0;
      fj_q    <= '0;
      fk_q    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
      qjv_q   <= 1'b0;
      qkv_q   <= 1'b0;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      op_q    <= op_d;
      fi_q    <= fi_d;
      fj_q    <= fj_d;
      fk_q    <= fk_d;
      qj_q    <= qj_d;
      qk_q    <= qk_d;
      qjv_q   <= qjv_d;
      qkv_q   <= qkv_d;
      rj_q    <= rj_d;
      rk_q    <= rk_d;
    end
  end

  assign busy     = (stage_q != ST_IDLE);
  assign rd_grant = (stage_q == ST_OPS) && rj_q && rk_q;
  assign wb_req   = (stage_q == ST_WB);
  assign op       = op_q;
  assign fi       = fi_q;
  assign fj       = fj_q;
  assign fk       = fk_q;
  assign rj       = rj_q;
  assign rk       = rk_q;

  // R2: the issue path only loads a free entry
  a_r2_issue_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> stage_q == ST_IDLE);

  // R4: operand read permission lasts one cycle
  a_r4_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |=> !rd_grant);

  // R8 / R9: write permission only reaches a unit that finished executing
  a_r8_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_win |-> stage_q == ST_WB);

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int NUM_FU = 4,
  parameter int REG_W  = 4,
  localparam int FU_W  = $clog2(NUM_FU)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_FU-1:0]            wb_req,
  input  logic [NUM_FU-1:0][REG_W-1:0] fi,
  input  logic [NUM_FU-1:0][REG_W-1:0] fj,
  input  logic [NUM_FU-1:0][REG_W-1:0] fk,
  input  logic [NUM_FU-1:0]            rj,
  input  logic [NUM_FU-1:0]            rk,
  output logic [NUM_FU-1:0]            wb_grant,
  output logic                         wb_valid,
  output logic [FU_W-1:0]              wb_unit
);

  logic [NUM_FU-1:0] war_block;
  logic [NUM_FU-1:0] eligible;

  // WAR: a writer waits while another entry still holds an unread copy
  // of its destination register as a source
  generate
    for (genvar u = 0; u < NUM_FU; u++) begin : g_war
      always_comb begin
        war_block[u] = 1'b0;
        for (int f = 0; f < NUM_FU; f++) begin
          if (f != u) begin
            if ((rj[f] && fj[f] == fi[u]) || (rk[f] && fk[f] == fi[u]))
              war_block[u] = 1'b1;
          end
        end
      end
    end
  endgenerate

  assign eligible = wb_req & ~war_block;

  // fixed priority, lowest unit id first
  always_comb begin
    wb_grant = '0;
    wb_unit  = '0;
    for (int u = NUM_FU - 1; u >= 0; u--) begin
      if (eligible[u]) begin
        wb_grant = '0;
        wb_grant[u] = 1'b1;
        wb_unit  = FU_W'(u);
      end
    end
  end

  assign wb_valid = |eligible;

  // R7: at most one unit writes per cycle
  a_r7_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant));

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 16,
  parameter int OP_W    = 4,
  localparam int FU_W   = $clog2(NUM_FU),
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [FU_W-1:0]         iss_unit,
  input  logic [OP_W-1:0]         iss_op,
  input  logic [REG_W-1:0]        iss_dst,
  input  logic [REG_W-1:0]        iss_src1,
  input  logic [REG_W-1:0]        iss_src2,
  output logic                    iss_ready,
  input  logic [NUM_FU-1:0]       ex_done,
  output logic [NUM_FU-1:0]       rd_grant,
  output logic [NUM_FU-1:0]       wb_grant,
  output logic [NUM_FU*OP_W-1:0]  fu_op,
  output logic [NUM_FU*REG_W-1:0] fu_dst,
  output logic [NUM_FU*REG_W-1:0] fu_src1,
  output logic [NUM_FU*REG_W-1:0] fu_src2
);

  logic [NUM_FU-1:0]            busy_v, wb_req_v, rj_v, rk_v;
  logic [NUM_FU-1:0][OP_W-1:0]  op_v;
  logic [NUM_FU-1:0][REG_W-1:0] fi_v, fj_v, fk_v;

  logic            wb_valid;
  logic [FU_W-1:0] wb_unit;

  logic            dst_pend, s1_pend, s2_pend;
  logic [FU_W-1:0] s1_fu, s2_fu;
  logic            unit_ok, iss_accept;
  logic            s1_rdy, s2_rdy;

  // structural and WAW checks against registered state
  assign unit_ok    = (32'(iss_unit) < NUM_FU);
  assign iss_ready  = unit_ok && !busy_v[iss_unit] && !dst_pend;
  assign iss_accept = iss_valid && iss_ready;

  // a producer writing in this very cycle counts as available
  assign s1_rdy = !s1_pend || (wb_valid && s1_fu == wb_unit);
  assign s2_rdy = !s2_pend || (wb_valid && s2_fu == wb_unit);

  sb_reg_status #(
    .NUM_REG (NUM_REG),
    .FU_W    (FU_W)
  ) u_regstat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (iss_accept),
    .set_reg  (iss_dst),
    .set_fu   (iss_unit),
    .clr_en   (wb_valid),
    .clr_fu   (wb_unit),
    .lk_dst   (iss_dst),
    .lk_s1    (iss_src1),
    .lk_s2    (iss_src2),
    .dst_pend (dst_pend),
    .s1_pend  (s1_pend),
    .s1_fu    (s1_fu),
    .s2_pend  (s2_pend),
    .s2_fu    (s2_fu)
  );

  generate
    for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
      sb_fu_entry #(
        .FU_W  (FU_W),
        .REG_W (REG_W),
        .OP_W  (OP_W)
      ) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_en (iss_accept && iss_unit == FU_W'(u)),
        .is_op    (iss_op),
        .is_dst   (iss_dst),
        .is_src1  (iss_src1),
        .is_src2  (iss_src2),
        .is_rdy1  (s1_rdy),
        .is_tag1  (s1_fu),
        .is_rdy2  (s2_rdy),
        .is_tag2  (s2_fu),
        .ex_done  (ex_done[u]),
        .bc_valid (wb_valid),
        .bc_unit  (wb_unit),
        .wb_win   (wb_grant[u]),
        .busy     (busy_v[u]),
        .rd_grant (rd_grant[u]),
        .wb_req   (wb_req_v[u]),
        .op       (op_v[u]),
        .fi       (fi_v[u]),
        .fj       (fj_v[u]),
        .fk       (fk_v[u]),
        .rj       (rj_v[u]),
        .rk       (rk_v[u])
      );
    end
  endgenerate

  sb_wb_arbiter #(
    .NUM_FU (NUM_FU),
    .REG_W  (REG_W)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_req   (wb_req_v),
    .fi       (fi_v),
    .fj       (fj_v),
    .fk       (fk_v),
    .rj       (rj_v),
    .rk       (rk_v),
    .wb_grant (wb_grant),
    .wb_valid (wb_valid),
    .wb_unit  (wb_unit)
  );

  assign fu_op   = op_v;
  assign fu_dst  = fi_v;
  assign fu_src1 = fj_v;
  assign fu_src2 = fk_v;

  // R2: an accepted instruction leaves its unit busy next cycle
  a_r2_accept_holds_unit: assert property (@(posedge clk) disable iff (!rst_n)
    iss_accept |=> busy_v[$past(iss_unit)]);

endmodule

// File: tb/sb_scoreboard_tb.sv
`timescale 1ns/1ps
module sb_scoreboard_tb;

  localparam int NFU = 4;
  localparam int NRG = 16;
  localparam int OPW = 4;
  localparam int FW  = 2;
  localparam int RW  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              iss_valid;
  logic [FW-1:0]     iss_unit;
  logic [OPW-1:0]    iss_op;
  logic [RW-1:0]     iss_dst, iss_src1, iss_src2;
  logic              iss_ready;
  logic [NFU-1:0]    ex_done;
  logic [NFU-1:0]    rd_grant, wb_grant;
  logic [NFU*OPW-1:0] fu_op;
  logic [NFU*RW-1:0]  fu_dst, fu_src1, fu_src2;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  sb_scoreboard #(.NUM_FU(NFU), .NUM_REG(NRG), .OP_W(OPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .ex_done(ex_done), .rd_grant(rd_grant),
    .wb_grant(wb_grant), .fu_op(fu_op), .fu_dst(fu_dst), .fu_src1(fu_src1),
    .fu_src2(fu_src2)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic drive_issue(input int unit, input int op, input int dst,
                             input int s1, input int s2);
    iss_valid = 1'b1;
    iss_unit  = FW'(unit);
    iss_op    = OPW'(op);
    iss_dst   = RW'(dst);
    iss_src1  = RW'(s1);
    iss_src2  = RW'(s2);
  endtask

  task automatic do_reset();
    iss_valid = 1'b0;
    iss_unit  = '0;
    iss_op    = '0;
    iss_dst   = '0;
    iss_src1  = '0;
    iss_src2  = '0;
    ex_done   = '0;
    rst_n     = 1'b0;
    #35;
    @(negedge clk);
    rst_n = 1'b1;
    tick();
  endtask

  // R1: idle state after reset
  task automatic t_reset();
    do_reset();
    drive_issue(2, 1, 9, 3, 4);
    iss_valid = 1'b0;
    settle();
    chk("R1 iss_ready after reset", 32'(iss_ready), 32'd1);
    chk("R1 rd_grant after reset", 32'(rd_grant), 32'd0);
    chk("R1 wb_grant after reset", 32'(wb_grant), 32'd0);
  endtask

  // R2, R4, R8 (early done ignored), R9, R10: single instruction life
  task automatic t_single();
    do_reset();
    drive_issue(1, 5, 3, 1, 2);
    settle();
    chk("R4 first issue accepted", 32'(iss_ready), 32'd1);
    tick();                                    // c1
    drive_issue(1, 6, 7, 1, 2);
    settle();
    chk("R2 busy unit stalls", 32'(iss_ready), 32'd0);
    iss_valid = 1'b0;
    chk("R4 read grant next cycle", 32'(rd_grant), 32'h2);
    chk("R10 op presented", 32'(fu_op[1*OPW +: OPW]), 32'd5);
    chk("R10 dst presented", 32'(fu_dst[1*RW +: RW]), 32'd3);
    chk("R10 src1 presented", 32'(fu_src1[1*RW +: RW]), 32'd1);
    chk("R10 src2 presented", 32'(fu_src2[1*RW +: RW]), 32'd2);
    tick();                                    // c2
    ex_done = 4'b0010;
    settle();
    chk("R4 read grant is one cycle", 32'(rd_grant), 32'd0);
    chk("R9 no write before done sampled", 32'(wb_grant), 32'd0);
    tick();                                    // c3
    ex_done = '0;
    drive_issue(1, 6, 7, 1, 2);
    settle();
    chk("R9 write grant after done", 32'(wb_grant), 32'h2);
    chk("R2 still busy in grant cycle", 32'(iss_ready), 32'd0);
    iss_valid = 1'b0;
    tick();                                    // c4
    drive_issue(1, 6, 7, 1, 2);
    settle();
    chk("R2 unit free after write", 32'(iss_ready), 32'd1);
    chk("R9 write grant one cycle", 32'(wb_grant), 32'd0);
    iss_valid = 1'b0;
  endtask

  // R3: write-after-write stall
  task automatic t_waw();
    do_reset();
    drive_issue(0, 2, 4, 1, 2);
    tick();                                    // c1
    drive_issue(2, 3, 4, 5, 6);
    settle();
    chk("R3 pending destination stalls", 32'(iss_ready), 32'd0);
    iss_valid = 1'b0;
    tick();                                    // c2
    ex_done = 4'b0001;
    tick();                                    // c3
    ex_done = '0;
    drive_issue(2, 3, 4, 5, 6);
    settle();
    chk("R3 producer writing", 32'(wb_grant), 32'h1);
    chk("R3 stall held in write cycle", 32'(iss_ready), 32'd0);
    iss_valid = 1'b0;
    tick();                                    // c4
    drive_issue(2, 3, 4, 5, 6);
    settle();
    chk("R3 destination free after write", 32'(iss_ready), 32'd1);
    iss_valid = 1'b0;
  endtask

  // R5 RAW and R8 stray done
  task automatic t_raw();
    do_reset();
    drive_issue(0, 1, 5, 1, 2);
    tick();                                    // c1
    drive_issue(1, 2, 6, 5, 2);
    settle();
    chk("R5 consumer accepted", 32'(iss_ready), 32'd1);
    tick();                                    // c2
    iss_valid = 1'b0;
    ex_done = 4'b0011;                         // bit 1 is a stray pulse
    settle();
    chk("R5 no read while source pending", 32'(rd_grant), 32'd0);
    tick();                                    // c3
    ex_done = '0;
    settle();
    chk("R8 only executing unit writes", 32'(wb_grant), 32'h1);
    chk("R5 no read in producer write cycle", 32'(rd_grant), 32'd0);
    tick();                                    // c4
    settle();
    chk("R5 read after producer write", 32'(rd_grant), 32'h2);
    chk("R8 stray done gave no write", 32'(wb_grant), 32'd0);
    tick();                                    // c5
    ex_done = 4'b0010;
    tick();                                    // c6
    ex_done = '0;
    settle();
    chk("R9 consumer writes after its done", 32'(wb_grant), 32'h2);
  endtask

  // R6: write-after-read hold
  task automatic t_war();
    do_reset();
    drive_issue(0, 1, 7, 1, 2);                // long producer of r7
    tick();                                    // c1
    drive_issue(1, 2, 8, 7, 3);                // reads r7 (pending) and r3
    tick();                                    // c2
    drive_issue(2, 3, 3, 1, 2);                // writes r3
    tick();                                    // c3
    iss_valid = 1'b0;
    settle();
    chk("R6 writer of r3 reads operands", 32'(rd_grant), 32'h4);
    tick();                                    // c4
    ex_done = 4'b0100;
    tick();                                    // c5
    ex_done = 4'b0001;
    settle();
    chk("R6 write held while r3 unread", 32'(wb_grant), 32'd0);
    tick();                                    // c6
    ex_done = '0;
    settle();
    chk("R6 unblocked producer writes", 32'(wb_grant), 32'h1);
    tick();                                    // c7
    settle();
    chk("R6 reader gets operands", 32'(rd_grant), 32'h2);
    chk("R6 still held in read cycle", 32'(wb_grant), 32'd0);
    tick();                                    // c8
    settle();
    chk("R6 released after read", 32'(wb_grant), 32'h4);
  endtask

  // R7: simultaneous finish
  task automatic t_prio();
    do_reset();
    drive_issue(3, 1, 9, 1, 2);
    tick();                                    // c1
    drive_issue(2, 1, 10, 1, 2);
    tick();                                    // c2
    iss_valid = 1'b0;
    tick();                                    // c3
    ex_done = 4'b1100;
    tick();                                    // c4
    ex_done = '0;
    settle();
    chk("R7 lowest id wins", 32'(wb_grant), 32'h4);
    tick();                                    // c5
    settle();
    chk("R7 loser granted next", 32'(wb_grant), 32'h8);
    tick();                                    // c6
    settle();
    chk("R7 no extra grant", 32'(wb_grant), 32'd0);
  endtask

  // R11: consumer issued in its producer's write cycle
  task automatic t_bypass();
    do_reset();
    drive_issue(0, 1, 11, 1, 2);
    tick();                                    // c1
    iss_valid = 1'b0;
    tick();                                    // c2
    ex_done = 4'b0001;
    tick();                                    // c3
    ex_done = '0;
    drive_issue(1, 4, 12, 11, 2);
    settle();
    chk("R11 producer writing", 32'(wb_grant), 32'h1);
    chk("R11 consumer accepted", 32'(iss_ready), 32'd1);
    tick();                                    // c4
    iss_valid = 1'b0;
    settle();
    chk("R11 consumer reads next cycle", 32'(rd_grant), 32'h2);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    t_reset();
    t_single();
    t_waw();
    t_raw();
    t_war();
    t_prio();
    t_bypass();
    summary();
  end

endmodule